// File: doc/BRIEF.md
# Multiprocessor break and single-step coordinator

This block is the common debug control for a cluster of up to sixteen processor cores. It holds two shared registers, a break/step register and a halt-propagation mask. Both are reached through a small register port that only answers when the request comes from core 0's register window. From these registers and from each core's debug status, the block drives three signals per core: a force-debug request, a one-cycle resume pulse and a single-step level.

Software breaks a core by setting its break bit. This takes effect only when that core's own break-on-watchpoint enable is set. Clearing the bit releases the core. A single-step bit lets a core run one instruction when it leaves debug mode. After the core reports that the instruction has retired, the block requests re-entry into debug mode. The step bit stays set afterwards.

The mask register selects which cores stop the whole cluster. When a selected core enters debug mode, every other core that is still running is asked to stop as well.

Top module: `mp_break_step`

## Requirements
- R1: After reset both registers read zero, and the force-debug, resume and single-step outputs are all low.
- R2: Break/step register bits [NCORES-1:0] are break bits, one per core. Bit x drives core_force[x] high only while core_bw_en[x] is high. The register update is visible one clock after the write.
- R3: A core's resume output pulses for exactly one cycle after a write changes its break bit from 1 to 0 while core_dbg for that core is high. No pulse occurs if the core is not in debug mode.
- R4: Break/step register bits [16+NCORES-1:16] are single-step bits. Bit 16+x appears as a level on core_step[x].
- R5: When a core with its step bit set leaves debug mode (core_dbg falls), core_force for that core stays low until a core_retired pulse arrives. It then rises in the next cycle and holds until core_dbg for that core is high again.
- R6: A step bit remains set after its core has re-entered debug mode.
- R7: Mask register bits [NCORES-1:0] each enable one core. When core x enters debug mode with mask bit x set, every core not in debug mode gets core_force high one clock later. Each such request drops once that core reports debug mode.
- R8: A core whose mask bit is clear causes no forced debug on any other core when it enters debug mode.
- R9: The register port acts only when reg_core is 0. Writes with any other ID are ignored, and reads with any other ID return zero. reg_sel 0 selects the break/step register and 1 selects the mask register.
- R10: Register bits for cores at or above NCORES always read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 break/step register, 1 mask register |
| reg_core | input | 4 | Index of the core issuing the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| core_dbg | input | NCORES | Core is in debug mode |
| core_bw_en | input | NCORES | Core's break-on-watchpoint enable |
| core_retired | input | NCORES | One-cycle pulse when a core retires an instruction |
| core_force | output | NCORES | Request to enter debug mode |
| core_resume | output | NCORES | One-cycle resume pulse |
| core_step | output | NCORES | Single-step enable level |

## Verification
Every combination of four break bits against four watchpoint enables is applied, which separates the gating of the request from the plain break bit. The resume path is tried with every debug-status pattern, so a pulse to a running core or a missed pulse to a halted one is exposed. Every mask value is combined with every source core, which tells apart propagation from a masked source, an unmasked source and the source itself. Step runs on each core hold the retire pulse back for several cycles, exposing a re-entry that comes early. Foreign-ID and out-of-range writes then read back the register contents.

// File: rtl/mpdbg_pkg.sv
package mpdbg_pkg;
  localparam int MAX_CORES = 16;
  localparam int SS_BASE   = 16;

  typedef enum logic [1:0] {
    STEP_IDLE    = 2'd0,
    STEP_RUN     = 2'd1,
    STEP_REENTER = 2'd2
  } step_state_e;

  // bit i set for each core that exists
  function automatic logic [MAX_CORES-1:0] present_mask(int n);
    logic [MAX_CORES-1:0] m;
    for (int i = 0; i < MAX_CORES; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [31:0] pack_break_step(logic [15:0] brk, logic [15:0] stp);
    return {stp, brk};
  endfunction

  // cores whose break bit falls while they sit in debug mode
  function automatic logic [15:0] resume_edges(logic [15:0] old_brk, logic [15:0] new_brk,
                                               logic [15:0] in_dbg);
    return old_brk & ~new_brk & in_dbg;
  endfunction

  // cores to be stopped when a masked core has just halted
  function automatic logic [15:0] halt_targets(logic [15:0] rise, logic [15:0] msk,
                                               logic [15:0] in_dbg);
    return (|(rise & msk)) ? ~in_dbg : 16'h0000;
  endfunction
endpackage

// File: rtl/mpdbg_regs.sv
module mpdbg_regs
  import mpdbg_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [3:0]        reg_core,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCORES-1:0] core_dbg,
  output logic [NCORES-1:0] brk_bits,
  output logic [NCORES-1:0] step_bits,
  output logic [NCORES-1:0] mask_bits,
  output logic [NCORES-1:0] resume_pulse
);
  localparam logic [15:0] PRESENT = present_mask(NCORES);

  logic              win_ok, wr_bs, wr_mask;
  logic [NCORES-1:0] brk_q, step_q, mask_q, resume_q;
  logic [15:0]       brk_w, step_w, mask_w, dbg_w, wbrk_w, res_w;

  assign win_ok  = (reg_core == 4'd0);
  assign wr_bs   = reg_wr & win_ok & ~reg_sel;
  assign wr_mask = reg_wr & win_ok &  reg_sel;

  always_comb begin
    brk_w  = '0; step_w = '0; mask_w = '0; dbg_w = '0; wbrk_w = '0;
    brk_w[NCORES-1:0]  = brk_q;
    step_w[NCORES-1:0] = step_q;
    mask_w[NCORES-1:0] = mask_q;
    dbg_w[NCORES-1:0]  = core_dbg;
    wbrk_w = reg_wdata[15:0] & PRESENT;
    res_w  = resume_edges(brk_w, wbrk_w, dbg_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q    <= '0;
      step_q   <= '0;
      mask_q   <= '0;
      resume_q <= '0;
    end else begin
      resume_q <= wr_bs ? res_w[NCORES-1:0] : '0;
      if (wr_bs) begin
        brk_q  <= reg_wdata[NCORES-1:0];
        step_q <= reg_wdata[SS_BASE +: NCORES];
      end
      if (wr_mask) mask_q <= reg_wdata[NCORES-1:0];
    end
  end

  always_comb begin
    if (!win_ok)      reg_rdata = '0;
    else if (reg_sel) reg_rdata = {16'h0000, mask_w};
    else              reg_rdata = pack_break_step(brk_w, step_w);
  end

  assign brk_bits     = brk_q;
  assign step_bits    = step_q;
  assign mask_bits    = mask_q;
  assign resume_pulse = resume_q;

  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_core != 4'd0) |=> ($stable(brk_q) && $stable(step_q) && $stable(mask_q))); // R9
  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_q != '0) |=> ((resume_q & $past(resume_q)) == '0)); // R3
  AST_ABSENT_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~{PRESENT, PRESENT}) == 32'h0); // R10
endmodule

// File: rtl/mpdbg_step.sv
module mpdbg_step
  import mpdbg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic dbg_now,
  input  logic dbg_fall,
  input  logic retired,
  output logic reenter
);
  step_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      STEP_IDLE:    if (step_en && dbg_fall) st_d = STEP_RUN;
      STEP_RUN:     if (retired)             st_d = STEP_REENTER;
      STEP_REENTER: if (dbg_now)             st_d = STEP_IDLE;
      default:                               st_d = STEP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= STEP_IDLE;
    else        st_q <= st_d;
  end

  assign reenter = (st_q == STEP_REENTER);

  AST_REENTER_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reenter) |-> $past(retired)); // R5
  AST_REENTER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (reenter && !dbg_now) |=> reenter); // R5
endmodule

// File: rtl/mpdbg_halt_prop.sv
module mpdbg_halt_prop
  import mpdbg_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCORES-1:0] core_dbg,
  input  logic [NCORES-1:0] mask_bits,
  output logic [NCORES-1:0] dbg_rise,
  output logic [NCORES-1:0] dbg_fall,
  output logic [NCORES-1:0] prop_req
);
  logic [NCORES-1:0] dbg_q, req_q;
  logic [15:0]       rise_w, mask_w, dbg_w, tgt_w;

  assign dbg_rise = core_dbg & ~dbg_q;
  assign dbg_fall = ~core_dbg & dbg_q;

  always_comb begin
    rise_w = '0; mask_w = '0; dbg_w = '0;
    rise_w[NCORES-1:0] = dbg_rise;
    mask_w[NCORES-1:0] = mask_bits;
    dbg_w[NCORES-1:0]  = core_dbg;
    tgt_w = halt_targets(rise_w, mask_w, dbg_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q <= '0;
      req_q <= '0;
    end else begin
      dbg_q <= core_dbg;
      req_q <= (req_q | tgt_w[NCORES-1:0]) & ~core_dbg;
    end
  end

  assign prop_req = req_q;

  for (genvar g = 0; g < NCORES; g++) begin : g_chk
    AST_PROP_DROPS_ON_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q[g] && core_dbg[g]) |=> !req_q[g]); // R7
    AST_PROP_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q[g]) |-> $past((dbg_rise & mask_bits) != '0)); // R8
  end
endmodule

// File: rtl/mp_break_step.sv
module mp_break_step #(
  parameter int NCORES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [3:0]        reg_core,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCORES-1:0] core_dbg,
  input  logic [NCORES-1:0] core_bw_en,
  input  logic [NCORES-1:0] core_retired,
  output logic [NCORES-1:0] core_force,
  output logic [NCORES-1:0] core_resume,
  output logic [NCORES-1:0] core_step
);
  logic [NCORES-1:0] brk_bits, step_bits, mask_bits;
  logic [NCORES-1:0] dbg_rise, dbg_fall, prop_req, reenter;

  mpdbg_regs #(.NCORES(NCORES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_core(reg_core), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_dbg(core_dbg), .brk_bits(brk_bits), .step_bits(step_bits),
    .mask_bits(mask_bits), .resume_pulse(core_resume)
  );

  mpdbg_halt_prop #(.NCORES(NCORES)) u_prop (
    .clk(clk), .rst_n(rst_n), .core_dbg(core_dbg), .mask_bits(mask_bits),
    .dbg_rise(dbg_rise), .dbg_fall(dbg_fall), .prop_req(prop_req)
  );

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    mpdbg_step u_step (
      .clk(clk), .rst_n(rst_n), .step_en(step_bits[g]), .dbg_now(core_dbg[g]),
      .dbg_fall(dbg_fall[g]), .retired(core_retired[g]), .reenter(reenter[g])
    );
  end

  assign core_force = (brk_bits & core_bw_en) | prop_req | reenter;
  assign core_step  = step_bits;

  AST_GATED_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_force & ~prop_req & ~reenter) & ~core_bw_en) == '0); // R2
endmodule

// File: tb/test_mp_break_step.sv
module test_mp_break_step;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [3:0] reg_core = 4'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] core_dbg = '0, core_bw_en = '0, core_retired = '0;
  logic [N-1:0] core_force, core_resume, core_step;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mp_break_step #(.NCORES(N)) i_mp_break_step (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_core(reg_core),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_dbg(core_dbg),
    .core_bw_en(core_bw_en), .core_retired(core_retired), .core_force(core_force),
    .core_resume(core_resume), .core_step(core_step)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [3:0] id, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_core = id; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_core = 4'd0;
  endtask

  task automatic rd(input string req, input logic sel, input logic [3:0] id,
                    input logic [31:0] exp);
    reg_sel = sel; reg_core = id; #1;
    chk(req, reg_rdata, exp);
    reg_core = 4'd0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd("R1", 1'b0, 4'd0, 32'h0);
    rd("R1", 1'b1, 4'd0, 32'h0);
    chk("R1", {core_force, core_resume, core_step}, '0);

    // R2 every break pattern against every watchpoint enable
    for (int p = 0; p < 16; p++) begin
      for (int b = 0; b < 16; b++) begin
        core_bw_en = p[N-1:0];
        wr(1'b0, 4'd0, 32'(b));
        chk("R2", 32'(core_force), 32'(b & p));
        chk("R3", 32'(core_resume), 32'h0);
        wr(1'b0, 4'd0, 32'h0);
        chk("R3", 32'(core_resume), 32'h0); // not in debug: no pulse
      end
    end
    core_bw_en = '0;

    // R3 resume for every debug-status pattern
    for (int d = 0; d < 16; d++) begin
      wr(1'b0, 4'd0, 32'hF);
      core_dbg = d[N-1:0];
      tick();
      wr(1'b0, 4'd0, 32'h0);
      chk("R3", 32'(core_resume), 32'(d));
      tick();
      chk("R3", 32'(core_resume), 32'h0);
      core_dbg = '0;
      tick();
    end

    // R7 / R8 every mask value with every source core
    for (int m = 0; m < 16; m++) begin
      wr(1'b1, 4'd0, 32'(m));
      for (int x = 0; x < N; x++) begin
        core_dbg = N'(1 << x);
        tick();
        if (m[x]) chk("R7", 32'(core_force), 32'((~(1 << x)) & 4'hF));
        else      chk("R8", 32'(core_force), 32'h0);
        core_dbg = '1;
        tick();
        chk("R7", 32'(core_force), 32'h0);
        core_dbg = '0;
        tick();
      end
    end
    wr(1'b1, 4'd0, 32'h0);

    // R4 R5 R6 single step on each core
    for (int x = 0; x < N; x++) begin
      core_dbg = N'(1 << x);
      tick();
      wr(1'b0, 4'd0, 32'(1) << (16 + x));
      chk("R4", 32'(core_step), 32'(1 << x));
      core_dbg = '0;
      tick();
      repeat (3) begin
        chk("R5", 32'(core_force), 32'h0);
        tick();
      end
      core_retired = N'(1 << x);
      tick();
      core_retired = '0;
      chk("R5", 32'(core_force), 32'(1 << x));
      tick();
      chk("R5", 32'(core_force), 32'(1 << x));
      core_dbg = N'(1 << x);
      tick();
      chk("R5", 32'(core_force), 32'h0);
      rd("R6", 1'b0, 4'd0, 32'(1) << (16 + x));
      wr(1'b0, 4'd0, 32'h0);
      core_dbg = '0;
      tick();
    end

    // R9 foreign window
    wr(1'b0, 4'd3, 32'h000F000F);
    wr(1'b1, 4'd1, 32'hF);
    rd("R9", 1'b0, 4'd0, 32'h0);
    rd("R9", 1'b1, 4'd0, 32'h0);
    wr(1'b0, 4'd0, 32'h00050003);
    rd("R9", 1'b0, 4'd2, 32'h0);
    rd("R9", 1'b0, 4'd0, 32'h00050003);

    // R10 absent core bits
    wr(1'b0, 4'd0, 32'hFFFFFFFF);
    rd("R10", 1'b0, 4'd0, 32'h000F000F);
    wr(1'b1, 4'd0, 32'hFFFFFFFF);
    rd("R10", 1'b1, 4'd0, 32'h0000000F);
    wr(1'b0, 4'd0, 32'h0);
    wr(1'b1, 4'd0, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule